// File: doc/BRIEF.md
# Cache Snoop Acceptance Controller

This block sits between a processor's external bus pins and its internal cache tags and decides when an outside bus master may probe the cache. A snoop strobe from outside counts only while the processor has given up the address bus: the hold has been acknowledged, the bus has been forced off, or the address pins are held by the system. Even then, several short windows refuse the strobe.

An accepted strobe captures the line address and the invalidate flag in the same clock. The next clock presents a lookup request to the tag store, which sits outside the block and returns a hit flag and a dirty flag during that clock. A dirty hit raises the hit-modified output two clocks after the strobe. It also raises a write-back request, which stays up until the bus answers with the first burst-ready. Hit-modified stays up until the fourth burst-ready of that write-back. A clean hit with invalidate set gives a one-clock invalidate command to the tags. A flag tells the system when the address hold may legally be released.

Only write-back cache operation is covered.

Top module: `snoop_accept_ctrl`

## Requirements
- R1: A strobe on `eads_i` is accepted only when at least one of `hlda_i`, `boff_i` or `ahold_i` is high in the same clock. At all other times it causes no lookup request.
- R2: A strobe is refused while `hitm_o` is high, in the clock after `ads_i` was high, and in the clock after an accepted strobe.
- R3: In the clock after an accepted strobe, `lkp_req_o` is high for one clock. `lkp_line_o` then carries address bits [ADDR_W-1:4] as they were in the strobe clock. The invalidate flag used is the value of `inv_i` in the strobe clock, even if `inv_i` changes later.
- R4: When the lookup returns `lkp_hit_i=1` and `lkp_dirty_i=1`, `hitm_o` goes high exactly two clocks after the strobe clock, and not one clock after it.
- R5: `hitm_o` stays high until the clock after the last burst-ready of the write-back. It is low at all other times.
- R6: While a hold condition remains and `hitm_o` stays low, a strobe held high continuously is accepted every other clock.
- R7: `wb_req_o` rises together with `hitm_o`. It falls in the clock after the first `brdy_i` of the write-back.
- R8: `ahold_ok_o` is high out of reset. It is low in the clock after an accepted strobe and high again from the second clock after the strobe.
- R9: A lookup with `lkp_hit_i=1` and `lkp_dirty_i=0`, with the captured invalidate flag set, drives `inval_o` high for exactly one clock, the second after the strobe. It never raises `hitm_o`. With the flag clear, `inval_o` stays low.
- R10: The write-back is complete after BURST_LEN (default 4) pulses of `brdy_i`. A `brdy_i` that arrives while no write-back is pending has no effect on that count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hlda_i | input | 1 | Bus hold acknowledged |
| boff_i | input | 1 | Processor forced off the bus |
| ahold_i | input | 1 | System holds the address pins |
| eads_i | input | 1 | External snoop address strobe, active high |
| ads_i | input | 1 | Internal bus cycle address strobe, active high |
| inv_i | input | 1 | Invalidate request accompanying the strobe |
| addr_i | input | ADDR_W | Snoop address from the bus |
| lkp_hit_i | input | 1 | Tag lookup hit, valid while `lkp_req_o` is high |
| lkp_dirty_i | input | 1 | Hit line is modified, valid while `lkp_req_o` is high |
| brdy_i | input | 1 | Burst-ready from the bus |
| lkp_req_o | output | 1 | Tag lookup request |
| lkp_line_o | output | ADDR_W-4 | Line address for the lookup |
| inval_o | output | 1 | One-clock invalidate command to the tags |
| hitm_o | output | 1 | Snoop hit a modified line, active high |
| wb_req_o | output | 1 | Write-back request for the modified line |
| ahold_ok_o | output | 1 | Minimum address-hold time has elapsed |

## Verification
The hardest case to reach from the ports is a strobe that meets a hold condition but falls inside a refusal window. The stimulus reaches each window the same way. It first creates the window with a legal event: an internal strobe, an accepted snoop, or a dirty hit that raises hit-modified. It then presents a fully qualified strobe in the very next clock and checks that no lookup request follows. A strobe held continuously under hold shows the accept-every-other-clock pattern. A burst-ready pulse sent before a dirty hit shows that the write-back count ignores pulses that arrive while no write-back is pending.

// File: rtl/snoop_accept_pkg.sv
package snoop_accept_pkg;
  localparam int unsigned LINE_LSB = 4;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/snoop_accept_gate.sv
module snoop_accept_gate (
  input  logic clk,
  input  logic rst,
  input  logic hlda_i,
  input  logic boff_i,
  input  logic ahold_i,
  input  logic eads_i,
  input  logic ads_i,
  input  logic hitm_i,
  input  logic lkp_busy_i,
  output logic accept_o
);
  logic ads_q;
  logic bus_released;
  logic blocked;

  always_ff @(posedge clk) begin
    if (rst) ads_q <= 1'b0;
    else     ads_q <= ads_i;
  end

  always_comb begin
    bus_released = hlda_i | boff_i | ahold_i;
    blocked      = hitm_i | ads_q | lkp_busy_i;
    accept_o     = eads_i & bus_released & ~blocked;
  end

  AST_NO_ACCEPT_AFTER_ADS: assert property (@(posedge clk) disable iff (rst)
    $past(ads_i) |-> !accept_o); // R2
endmodule

// File: rtl/snoop_capture.sv
module snoop_capture #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LINE_LSB = 4,
  localparam int unsigned LINE_W  = ADDR_W - LINE_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              inv_i,
  output logic              lkp_req_o,
  output logic [LINE_W-1:0] lkp_line_o,
  output logic              inv_q_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lkp_req_o  <= 1'b0;
      lkp_line_o <= '0;
      inv_q_o    <= 1'b0;
    end else begin
      lkp_req_o <= accept_i;
      if (accept_i) begin
        lkp_line_o <= addr_i[ADDR_W-1:LINE_LSB];
        inv_q_o    <= inv_i;
      end
    end
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    lkp_req_o |=> !lkp_req_o); // R6
endmodule

// File: rtl/snoop_wb_tracker.sv
module snoop_wb_tracker #(
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned CNT_W = snoop_accept_pkg::cnt_width(BURST_LEN)
) (
  input  logic clk,
  input  logic rst,
  input  logic lkp_req_i,
  input  logic lkp_hit_i,
  input  logic lkp_dirty_i,
  input  logic inv_q_i,
  input  logic brdy_i,
  output logic hitm_o,
  output logic wb_req_o,
  output logic inval_o
);
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BURST_LEN - 1);

  logic [CNT_W-1:0] beat_cnt;
  logic             dirty_hit;
  logic             clean_inv;

  always_comb begin
    dirty_hit = lkp_req_i & lkp_hit_i & lkp_dirty_i;
    clean_inv = lkp_req_i & lkp_hit_i & ~lkp_dirty_i & inv_q_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hitm_o   <= 1'b0;
      wb_req_o <= 1'b0;
      inval_o  <= 1'b0;
      beat_cnt <= '0;
    end else begin
      inval_o <= clean_inv;
      if (dirty_hit) begin
        hitm_o   <= 1'b1;
        wb_req_o <= 1'b1;
        beat_cnt <= '0;
      end else if (hitm_o && brdy_i) begin
        wb_req_o <= 1'b0;
        if (beat_cnt == LAST_BEAT) begin
          hitm_o   <= 1'b0;
          beat_cnt <= '0;
        end else begin
          beat_cnt <= beat_cnt + 1'b1;
        end
      end
    end
  end

  AST_HITM_FROM_LOOKUP: assert property (@(posedge clk) disable iff (rst)
    $rose(hitm_o) |-> $past(lkp_req_i && lkp_hit_i && lkp_dirty_i)); // R4
  AST_HITM_DROP_ON_BRDY: assert property (@(posedge clk) disable iff (rst)
    $fell(hitm_o) |-> $past(brdy_i)); // R5
  AST_INVAL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    inval_o |-> !hitm_o); // R9
  AST_INVAL_PULSE: assert property (@(posedge clk) disable iff (rst)
    inval_o |=> !inval_o); // R9
  AST_WBREQ_INSIDE_HITM: assert property (@(posedge clk) disable iff (rst)
    wb_req_o |-> hitm_o); // R7
endmodule

// File: rtl/snoop_ahold_timer.sv
module snoop_ahold_timer #(
  parameter int unsigned MIN_HOLD_CLKS = 2,
  localparam int unsigned CNT_W = snoop_accept_pkg::cnt_width(MIN_HOLD_CLKS)
) (
  input  logic clk,
  input  logic rst,
  input  logic accept_i,
  output logic ahold_ok_o
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(MIN_HOLD_CLKS - 1);

  logic [CNT_W-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst)                   wait_cnt <= '0;
    else if (accept_i)         wait_cnt <= LOAD_VAL;
    else if (wait_cnt != '0)   wait_cnt <= wait_cnt - 1'b1;
  end

  assign ahold_ok_o = (wait_cnt == '0);

  AST_AHOLD_MIN: assert property (@(posedge clk) disable iff (rst)
    $past(accept_i) |-> !ahold_ok_o); // R8
endmodule

// File: rtl/snoop_accept_ctrl.sv
module snoop_accept_ctrl #(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned BURST_LEN     = 4,
  parameter int unsigned MIN_HOLD_CLKS = 2,
  localparam int unsigned LINE_W = ADDR_W - snoop_accept_pkg::LINE_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hlda_i,
  input  logic              boff_i,
  input  logic              ahold_i,
  input  logic              eads_i,
  input  logic              ads_i,
  input  logic              inv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              lkp_hit_i,
  input  logic              lkp_dirty_i,
  input  logic              brdy_i,
  output logic              lkp_req_o,
  output logic [LINE_W-1:0] lkp_line_o,
  output logic              inval_o,
  output logic              hitm_o,
  output logic              wb_req_o,
  output logic              ahold_ok_o
);
  logic accept;
  logic inv_q;

  snoop_accept_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .hlda_i     (hlda_i),
    .boff_i     (boff_i),
    .ahold_i    (ahold_i),
    .eads_i     (eads_i),
    .ads_i      (ads_i),
    .hitm_i     (hitm_o),
    .lkp_busy_i (lkp_req_o),
    .accept_o   (accept)
  );

  snoop_capture #(
    .ADDR_W   (ADDR_W),
    .LINE_LSB (snoop_accept_pkg::LINE_LSB)
  ) u_capture (
    .clk        (clk),
    .rst        (rst),
    .accept_i   (accept),
    .addr_i     (addr_i),
    .inv_i      (inv_i),
    .lkp_req_o  (lkp_req_o),
    .lkp_line_o (lkp_line_o),
    .inv_q_o    (inv_q)
  );

  snoop_wb_tracker #(
    .BURST_LEN (BURST_LEN)
  ) u_tracker (
    .clk         (clk),
    .rst         (rst),
    .lkp_req_i   (lkp_req_o),
    .lkp_hit_i   (lkp_hit_i),
    .lkp_dirty_i (lkp_dirty_i),
    .inv_q_i     (inv_q),
    .brdy_i      (brdy_i),
    .hitm_o      (hitm_o),
    .wb_req_o    (wb_req_o),
    .inval_o     (inval_o)
  );

  snoop_ahold_timer #(
    .MIN_HOLD_CLKS (MIN_HOLD_CLKS)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .accept_i   (accept),
    .ahold_ok_o (ahold_ok_o)
  );

  AST_ACCEPT_NEEDS_HOLD: assert property (@(posedge clk) disable iff (rst)
    lkp_req_o |-> $past(hlda_i || boff_i || ahold_i)); // R1
  AST_ACCEPT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    lkp_req_o |-> $past(eads_i)); // R3
  AST_NO_ACCEPT_DURING_HITM: assert property (@(posedge clk) disable iff (rst)
    $past(hitm_o) |-> !lkp_req_o); // R2
  AST_HITM_QUIET_AT_LOOKUP: assert property (@(posedge clk) disable iff (rst)
    lkp_req_o |-> !hitm_o); // R4
endmodule

// File: tb/snoop_accept_ctrl_tb_top.sv
module snoop_accept_ctrl_tb_top;
  localparam int unsigned ADDR_W = 32;

  logic clk = 1'b0;
  logic rst;
  logic hlda_i, boff_i, ahold_i, eads_i, ads_i, inv_i;
  logic [ADDR_W-1:0] addr_i;
  logic lkp_hit_i, lkp_dirty_i, brdy_i;
  logic lkp_req_o, inval_o, hitm_o, wb_req_o, ahold_ok_o;
  logic [ADDR_W-5:0] lkp_line_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  snoop_accept_ctrl dut_i (
    .clk(clk), .rst(rst), .hlda_i(hlda_i), .boff_i(boff_i), .ahold_i(ahold_i),
    .eads_i(eads_i), .ads_i(ads_i), .inv_i(inv_i), .addr_i(addr_i),
    .lkp_hit_i(lkp_hit_i), .lkp_dirty_i(lkp_dirty_i), .brdy_i(brdy_i),
    .lkp_req_o(lkp_req_o), .lkp_line_o(lkp_line_o), .inval_o(inval_o),
    .hitm_o(hitm_o), .wb_req_o(wb_req_o), .ahold_ok_o(ahold_ok_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    hlda_i = 0; boff_i = 0; ahold_i = 0; eads_i = 0; ads_i = 0; inv_i = 0;
    addr_i = '0; lkp_hit_i = 0; lkp_dirty_i = 0; brdy_i = 0;
  endtask

  task automatic t_reset();
    chk("R8", "ahold_ok after reset", ahold_ok_o, 1);
    chk("R5", "hitm after reset", hitm_o, 0);
    chk("R3", "lkp_req after reset", lkp_req_o, 0);
    chk("R7", "wb_req after reset", wb_req_o, 0);
  endtask

  task automatic t_no_hold();
    eads_i = 1; addr_i = 32'h1234_5670;
    tick();
    eads_i = 0;
    chk("R1", "lkp_req without hold", lkp_req_o, 0);
    tick();
  endtask

  task automatic t_each_hold();
    for (int k = 0; k < 3; k++) begin
      hlda_i = (k == 0); boff_i = (k == 1); ahold_i = (k == 2);
      eads_i = 1; addr_i = 32'hA000_0000 + (k << 8) + 32'h7;
      tick();
      eads_i = 0; addr_i = 32'hFFFF_FFFF;
      chk("R1", "lkp_req under hold", lkp_req_o, 1);
      chk("R3", "line address", lkp_line_o, (32'hA000_0000 + (k << 8)) >> 4);
      chk("R8", "ahold_ok low after strobe", ahold_ok_o, 0);
      tick();
      chk("R3", "lkp_req single clock", lkp_req_o, 0);
      chk("R8", "ahold_ok high two after", ahold_ok_o, 1);
      chk("R4", "miss gives no hitm", hitm_o, 0);
      hlda_i = 0; boff_i = 0; ahold_i = 0;
      tick();
    end
  endtask

  task automatic t_clean_inval(input logic inv);
    hlda_i = 1; eads_i = 1; inv_i = inv; addr_i = 32'h0000_0F40;
    tick();
    eads_i = 0; inv_i = ~inv;
    chk("R3", "lkp_req clean", lkp_req_o, 1);
    lkp_hit_i = 1; lkp_dirty_i = 0;
    tick();
    lkp_hit_i = 0;
    chk("R9", "inval after clean hit", inval_o, inv);
    chk("R9", "no hitm on clean hit", hitm_o, 0);
    tick();
    chk("R9", "inval one clock", inval_o, 0);
    hlda_i = 0;
    tick();
  endtask

  task automatic t_ads_window();
    hlda_i = 1; ads_i = 1;
    tick();
    ads_i = 0; eads_i = 1; addr_i = 32'h0000_2000;
    tick();
    chk("R2", "refused after ads", lkp_req_o, 0);
    tick();
    eads_i = 0;
    chk("R2", "accepted once ads window ends", lkp_req_o, 1);
    tick();
    hlda_i = 0;
    tick();
  endtask

  task automatic t_back_to_back();
    boff_i = 1; eads_i = 1; addr_i = 32'h0000_3000;
    tick();
    chk("R6", "b2b first accept", lkp_req_o, 1);
    tick();
    chk("R2", "refused clock after accept", lkp_req_o, 0);
    tick();
    chk("R6", "b2b second accept", lkp_req_o, 1);
    eads_i = 0;
    tick();
    chk("R6", "b2b idle after", lkp_req_o, 0);
    boff_i = 0;
    tick();
  endtask

  task automatic t_dirty_writeback();
    brdy_i = 1;
    tick(); tick();
    brdy_i = 0;
    chk("R10", "stray brdy no hitm", hitm_o, 0);
    ahold_i = 1; eads_i = 1; addr_i = 32'h0000_5550;
    tick();
    eads_i = 0;
    chk("R4", "no hitm one clock after strobe", hitm_o, 0);
    chk("R8", "ahold_ok low dirty", ahold_ok_o, 0);
    lkp_hit_i = 1; lkp_dirty_i = 1;
    tick();
    lkp_hit_i = 0; lkp_dirty_i = 0;
    chk("R4", "hitm two clocks after strobe", hitm_o, 1);
    chk("R7", "wb_req with hitm", wb_req_o, 1);
    chk("R8", "ahold_ok high dirty", ahold_ok_o, 1);
    eads_i = 1; addr_i = 32'h0000_6660;
    tick();
    eads_i = 0;
    chk("R2", "refused during hitm", lkp_req_o, 0);
    chk("R7", "wb_req held before brdy", wb_req_o, 1);
    brdy_i = 1;
    tick();
    chk("R7", "wb_req drops after first brdy", wb_req_o, 0);
    chk("R5", "hitm after beat 1", hitm_o, 1);
    tick(); tick();
    chk("R10", "hitm after beat 3", hitm_o, 1);
    tick();
    brdy_i = 0;
    chk("R5", "hitm drops after beat 4", hitm_o, 0);
    tick();
    chk("R5", "hitm stays low", hitm_o, 0);
    ahold_i = 0;
    tick();
  endtask

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    tick();
    t_reset();
    t_no_hold();
    t_each_hold();
    t_clean_inval(1'b1);
    t_clean_inval(1'b0);
    t_ads_window();
    t_back_to_back();
    t_dirty_writeback();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule